// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block produces eight pulse-width-modulated outputs from a single 16-bit up-counter. Every channel uses the same period. A channel output stays active while the count is below that channel's compare value, and goes inactive for the rest of the period. The counter advances on enable pulses taken from one of three tick inputs. A power-of-two prescaler divides those pulses first. Each period runs from a programmable start value up to a programmable top value, and then the counter reloads the start value.

A simple synchronous register port sets up the block: address, write data, write strobe, and a combinational read-data bus. Each channel can be inverted on its own. Each channel can also be masked, and a masked channel drives a programmable idle level. Writes to the top value and to the compare values are held in shadow registers. They take effect only when a period ends, so software never produces a truncated or stretched pulse. When the counter is stopped, the shadows are copied straight away. A write to the count register restarts the period from the start value.

Register word addresses: CFG 0x00, COUNT 0x04, TOP 0x08, START 0x0C, IDLE 0x10, MASK 0x14, INVERT 0x18, channel n compare value 0x20+4n, channel n mode 0x40+4n. An address not listed here reads as 0.

Top module: `pwm8_timer`

## Requirements
- R1: After reset the outputs are all 0. MASK reads 0xFF, TOP reads 0xFFFF, and CFG, COUNT, START, IDLE, INVERT and all compare values read 0.
- R2: CFG[4:3] selects the count source. 0 freezes the counter, 1 uses tick_sys, 2 uses tick_fix and 3 uses tick_ext. Pulses on the tick inputs that are not selected have no effect on COUNT.
- R3: CFG[2:0] holds PS. The counter advances once every 2^PS pulses of the selected source.
- R4: The counter counts up by one from START. When it advances from a value at or above TOP, it reloads START, so one period is TOP-START+1 advances.
- R5: A channel runs edge-aligned PWM only when bits 5 and 3 of its mode register are both set. Otherwise its pre-polarity level is 0. Mode bits [5:2] read back, and the other bits read 0.
- R6: In PWM mode the pre-polarity level is 1 while COUNT is below the channel's compare value. A compare value of 0 gives a constant 0, and a value above TOP gives a constant 1.
- R7: INVERT bit n inverts output n after the compare and mask logic.
- R8: When MASK bit n is set, output n equals IDLE bit n XOR INVERT bit n, whatever the compare result.
- R9: New TOP and compare values are used from the first period that starts after the write. While CFG[4:3] is 0 they are used from the next clock.
- R10: COUNT reads back the live count. Any write to COUNT loads START into the counter and clears the prescaler phase.
- R11: Each register reads back its last written value, masked to its width: CFG 5 bits, TOP, START and compare values 16 bits, IDLE, MASK and INVERT 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_sys | input | 1 | System-rate count enable pulse |
| tick_fix | input | 1 | Fixed-rate count enable pulse |
| tick_ext | input | 1 | External count enable pulse |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one register write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 8 | Channel outputs |

## Verification
The counter state can be read over the bus, so the bench reads COUNT one cycle after each edge. A wrong increment, reload, prescaler phase or source choice therefore appears on the very next cycle. A shadow register loaded at the wrong time shows up differently. pwm_out toggles at the old threshold instead of the new one, but only once COUNT crosses the affected value. For that reason the bench writes the new value part-way through a period and then watches that period to its end and the one after it. Errors in mask and polarity appear combinationally on pwm_out in the same cycle as the register changes.

// File: rtl/pwm8_timer.sv
module pwm8_timer #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_sys,
  input  logic        tick_fix,
  input  logic        tick_ext,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_we,
  output logic [31:0] bus_rdata,
  output logic [7:0]  pwm_out
);
  localparam int NCH = 8;
  localparam int DVW = 7;

  logic [1:0]    src_q;
  logic [2:0]    ps_q;
  logic [DVW-1:0] div_q;
  logic [CW-1:0] cnt_q, top_sh, top_q, start_q;
  logic [NCH-1:0] idle_q, mask_q, inv_q;
  logic [CW-1:0] cmp_sh [NCH];
  logic [CW-1:0] cmp_q  [NCH];
  logic [3:0]    mode_q [NCH];

  wire [2:0] ch = bus_addr[4:2];
  wire wr_cfg   = bus_we && bus_addr == 8'h00;
  wire wr_cnt   = bus_we && bus_addr == 8'h04;
  wire wr_top   = bus_we && bus_addr == 8'h08;
  wire wr_start = bus_we && bus_addr == 8'h0C;
  wire wr_idle  = bus_we && bus_addr == 8'h10;
  wire wr_mask  = bus_we && bus_addr == 8'h14;
  wire wr_inv   = bus_we && bus_addr == 8'h18;
  wire wr_cmp   = bus_we && bus_addr[7:5] == 3'b001 && bus_addr[1:0] == 2'b00;
  wire wr_mode  = bus_we && bus_addr[7:5] == 3'b010 && bus_addr[1:0] == 2'b00;

  logic tick;
  always_comb begin
    case (src_q)
      2'd1:    tick = tick_sys;
      2'd2:    tick = tick_fix;
      2'd3:    tick = tick_ext;
      default: tick = 1'b0;
    endcase
  end

  wire [DVW-1:0] div_lim = (DVW'(1) << ps_q) - DVW'(1);
  wire div_last = div_q >= div_lim;
  wire adv      = tick && div_last;
  wire wrap     = adv && cnt_q >= top_q;
  wire load     = wrap || src_q == 2'd0 || wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      ps_q    <= '0;
      div_q   <= '0;
      cnt_q   <= '0;
      top_sh  <= '1;
      top_q   <= '1;
      start_q <= '0;
      idle_q  <= '0;
      mask_q  <= '1;
      inv_q   <= '0;
    end else begin
      if (wr_cfg) begin
        src_q <= bus_wdata[4:3];
        ps_q  <= bus_wdata[2:0];
      end
      if (wr_cnt)      div_q <= '0;
      else if (tick)   div_q <= div_last ? '0 : div_q + DVW'(1);
      if (wr_cnt)      cnt_q <= start_q;
      else if (adv)    cnt_q <= wrap ? start_q : cnt_q + CW'(1);
      if (wr_top)   top_sh  <= bus_wdata[CW-1:0];
      if (load)     top_q   <= top_sh;
      if (wr_start) start_q <= bus_wdata[CW-1:0];
      if (wr_idle)  idle_q  <= bus_wdata[NCH-1:0];
      if (wr_mask)  mask_q  <= bus_wdata[NCH-1:0];
      if (wr_inv)   inv_q   <= bus_wdata[NCH-1:0];
    end
  end

  logic [NCH-1:0] raw;
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_sh[n] <= '0;
        cmp_q[n]  <= '0;
        mode_q[n] <= '0;
      end else begin
        if (wr_cmp && ch == 3'(n))  cmp_sh[n] <= bus_wdata[CW-1:0];
        if (wr_mode && ch == 3'(n)) mode_q[n] <= bus_wdata[5:2];
        if (load)                   cmp_q[n]  <= cmp_sh[n];
      end
    end
    assign raw[n] = mode_q[n][3] && mode_q[n][1] && (cnt_q < cmp_q[n]);

    assert_zero_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_q[n] == '0 && !mask_q[n]) |-> pwm_out[n] == inv_q[n]);
  end

  assign pwm_out = ((mask_q & idle_q) | (~mask_q & raw)) ^ inv_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      8'h00: bus_rdata = {27'd0, src_q, ps_q};
      8'h04: bus_rdata = 32'(cnt_q);
      8'h08: bus_rdata = 32'(top_sh);
      8'h0C: bus_rdata = 32'(start_q);
      8'h10: bus_rdata = 32'(idle_q);
      8'h14: bus_rdata = 32'(mask_q);
      8'h18: bus_rdata = 32'(inv_q);
      default: begin
        if (bus_addr[7:5] == 3'b001 && bus_addr[1:0] == 2'b00)
          bus_rdata = 32'(cmp_sh[ch]);
        else if (bus_addr[7:5] == 3'b010 && bus_addr[1:0] == 2'b00)
          bus_rdata = {26'd0, mode_q[ch], 2'b00};
      end
    endcase
  end

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'd0 && !wr_cnt) |=> cnt_q == $past(cnt_q));

  assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q >= top_q && !wr_cnt) |=> cnt_q == $past(start_q));

  assert_count_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(start_q) && div_q == '0));

  assert_mask_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_out ^ inv_q) & mask_q) == (idle_q & mask_q));

  assert_top_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && src_q != 2'd0 && !wr_cnt) |=> top_q == $past(top_q));

endmodule

// File: tb/tb_pwm8_timer.sv
`timescale 1ns/1ps
module tb_pwm8_timer;
  logic clk = 0, rst_n = 0;
  logic tick_sys = 0, tick_fix = 0, tick_ext = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic bus_we = 0;
  logic [31:0] bus_rdata;
  logic [7:0] pwm_out;
  int n_chk = 0, n_bad = 0;

  localparam logic [7:0] A_CFG = 8'h00, A_CNT = 8'h04, A_TOP = 8'h08, A_START = 8'h0C,
                         A_IDLE = 8'h10, A_MASK = 8'h14, A_INV = 8'h18;

  pwm8_timer dut (.clk(clk), .rst_n(rst_n), .tick_sys(tick_sys), .tick_fix(tick_fix),
    .tick_ext(tick_ext), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic setup(input logic [7:0] m);
    wr(A_CFG, 0); wr(A_TOP, 9); wr(A_START, 0);
    wr(A_IDLE, 0); wr(A_INV, 0); wr(A_MASK, 32'(m));
  endtask

  task automatic arm();
    wr(A_CNT, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 outputs", 32'(pwm_out), 0);
    rd(A_MASK, d);  chk("R1 mask", d, 32'hFF);
    rd(A_TOP, d);   chk("R1 top", d, 32'hFFFF);
    rd(A_CFG, d);   chk("R1 cfg", d, 0);
    rd(A_CNT, d);   chk("R1 count", d, 0);
    rd(8'h24, d);   chk("R1 compare", d, 0);
  endtask

  task automatic t_frozen();
    logic [31:0] d;
    setup(8'hFE); wr(8'h20, 3); wr(8'h40, 32'h28); arm();
    tick_sys = 1; tick_fix = 1; tick_ext = 1;
    repeat (5) @(negedge clk);
    rd(A_CNT, d); chk("R2 frozen", d, 0);
    tick_sys = 0; tick_fix = 0; tick_ext = 0;
  endtask

  task automatic t_basic();
    logic [31:0] d;
    setup(8'hFE); wr(8'h20, 3); wr(8'h40, 32'h28); arm();
    tick_sys = 1;
    wr(A_CFG, 32'h08);
    for (int k = 0; k < 25; k++) begin
      rd(A_CNT, d);
      chk("R4 count", d, k % 10);
      chk("R6 pwm", 32'(pwm_out), ((k % 10) < 3) ? 1 : 0);
      @(negedge clk);
    end
    tick_sys = 0; wr(A_CFG, 0);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    setup(8'hFE); arm();
    tick_sys = 1;
    wr(A_CFG, 32'h0A);
    for (int k = 0; k < 20; k++) begin
      rd(A_CNT, d);
      chk("R3 prescale", d, (k / 4) % 10);
      @(negedge clk);
    end
    tick_sys = 0; wr(A_CFG, 0);
  endtask

  task automatic t_source();
    logic [31:0] d;
    setup(8'hFE); arm();
    tick_sys = 1; tick_ext = 1;
    wr(A_CFG, 32'h10);
    repeat (3) @(negedge clk);
    rd(A_CNT, d); chk("R2 other sources ignored", d, 0);
    tick_sys = 0; tick_ext = 0;
    for (int i = 0; i < 5; i++) begin
      tick_fix = 1; @(negedge clk); tick_fix = 0; @(negedge clk);
    end
    rd(A_CNT, d); chk("R2 fixed source", d, 5);
    wr(A_CFG, 32'h18);
    for (int i = 0; i < 2; i++) begin
      tick_ext = 1; @(negedge clk); tick_ext = 0; @(negedge clk);
    end
    rd(A_CNT, d); chk("R2 external source", d, 7);
    wr(A_CFG, 0);
  endtask

  task automatic t_edges();
    setup(8'hF1);
    wr(8'h24, 0);    wr(8'h44, 32'h28);
    wr(8'h28, 32'h20); wr(8'h48, 32'h28);
    wr(8'h2C, 5);    wr(8'h4C, 32'h08);
    arm();
    tick_sys = 1;
    wr(A_CFG, 32'h08);
    for (int k = 0; k < 12; k++) begin
      chk("R6 R5 R8 edge values", 32'(pwm_out), 32'h04);
      @(negedge clk);
    end
    tick_sys = 0; wr(A_CFG, 0);
  endtask

  task automatic t_polmask();
    setup(8'hFE); wr(8'h20, 3); wr(8'h40, 32'h28);
    wr(A_IDLE, 32'h42); wr(A_INV, 32'h81);
    arm();
    tick_sys = 1;
    wr(A_CFG, 32'h08);
    for (int k = 0; k < 12; k++) begin
      chk("R7 R8 polarity and idle", 32'(pwm_out), 32'hC2 | (((k % 10) < 3) ? 0 : 1));
      @(negedge clk);
    end
    tick_sys = 0; wr(A_CFG, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    setup(8'hFE); wr(8'h20, 3); wr(8'h40, 32'h28); arm();
    tick_sys = 1;
    wr(A_CFG, 32'h08);
    for (int k = 0; k < 4; k++) begin
      chk("R9 before write", 32'(pwm_out), (k < 3) ? 1 : 0);
      @(negedge clk);
    end
    wr(8'h20, 7);
    wr(A_TOP, 5);
    for (int k = 6; k < 10; k++) begin
      rd(A_CNT, d); chk("R9 old top kept", d, k);
      chk("R9 old compare kept", 32'(pwm_out), (k < 3) ? 1 : 0);
      @(negedge clk);
    end
    for (int k = 10; k < 22; k++) begin
      rd(A_CNT, d); chk("R9 new top", d, (k - 10) % 6);
      chk("R9 new compare", 32'(pwm_out), 1);
      @(negedge clk);
    end
    tick_sys = 0; wr(A_CFG, 0);
    rd(A_CNT, d);
    wr(8'h20, 2);
    @(negedge clk);
    chk("R9 stopped immediate", 32'(pwm_out), (d < 2) ? 1 : 0);
  endtask

  task automatic t_count();
    logic [31:0] d, c;
    setup(8'hFE); wr(A_START, 4); wr(8'h20, 6); wr(8'h40, 32'h28); arm();
    rd(A_CNT, d); chk("R10 count write loads start", d, 4);
    tick_sys = 1;
    wr(A_CFG, 32'h09);
    repeat (2) @(negedge clk);
    rd(A_CNT, d); chk("R10 advancing", d, 5);
    wr(A_CNT, 32'h1234);
    for (int k = 0; k < 26; k++) begin
      c = 4 + ((k / 2) % 6);
      rd(A_CNT, d); chk("R10 R4 restart from start", d, c);
      chk("R4 pwm with start", 32'(pwm_out), (c < 6) ? 1 : 0);
      @(negedge clk);
    end
    tick_sys = 0; wr(A_CFG, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(A_IDLE, 32'hFF5A);   rd(A_IDLE, d);  chk("R11 idle", d, 32'h5A);
    wr(A_INV, 32'h3C);      rd(A_INV, d);   chk("R11 invert", d, 32'h3C);
    wr(A_MASK, 32'hA5);     rd(A_MASK, d);  chk("R11 mask", d, 32'hA5);
    wr(A_START, 32'h1BEEF); rd(A_START, d); chk("R11 start", d, 32'hBEEF);
    wr(8'h34, 32'hFFFF1234); rd(8'h34, d);  chk("R11 compare", d, 32'h1234);
    wr(8'h54, 32'hFF);      rd(8'h54, d);   chk("R5 mode readback", d, 32'h3C);
    wr(A_CFG, 32'hFF);      rd(A_CFG, d);   chk("R11 cfg", d, 32'h1F);
    rd(8'h1C, d); chk("R11 unmapped", d, 0);
    wr(A_CFG, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_frozen();
    t_basic();
    t_prescale();
    t_source();
    t_edges();
    t_polmask();
    t_shadow();
    t_count();
    t_readback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule